// File: doc/BRIEF.md
# Event Ring Producer

This block turns hardware event requests into fixed-size records in a circular ring that lives in a plain word-addressed memory. Each request carries a 10-bit event type and seven 64-bit payload words. The block writes one 64-bit memory word per accepted memory cycle. For each record it writes the seven payload words first. It then writes the header word, whose control half holds the event type and a ready flag. Once that header write has been accepted, it raises a one-cycle interrupt on a fixed vector. Then it moves its producer index forward by one slot, wrapping around at the end of the ring.

The consumer drains the ring and reports its progress back through a consumer index input. The producer compares that index with its own next index. When advancing would make the two equal, the ring counts as full and the request is held off until the consumer frees a slot. Only one record is ever being written at a time.

Top module: `evring_producer`

## Requirements
- R1: Out of reset the producer index is 0, no memory write is requested, the interrupt is low and, with the consumer index at 0, a request is accepted (req_ready high).
- R2: For the record in slot i, payload word k (k = 0..6, bits 64k+63:64k of req_payload) is written to word address 8i+1+k, in increasing k order, before the header.
- R3: The header word of slot i is written last, at word address 8i. Bits 31:0 are zero (the reserved word). Bit 63 is the ready flag and is 1. Bits 57:48 hold the event type. All other bits are zero.
- R4: While mem_wr_valid is high and mem_wr_ready is low, mem_wr_addr and mem_wr_data hold their values and mem_wr_valid stays high.
- R5: irq_pulse is high for exactly one cycle: the cycle after the header write is accepted. irq_vec always reads 5.
- R6: The producer index advances by one in the cycle after the header write is accepted, and goes from 63 back to 0.
- R7: When (prod_idx+1) mod 64 equals cons_idx, req_ready is low and no write starts. req_ready rises in the same cycle that cons_idx moves away from that value.
- R8: Once a request is accepted, req_ready stays low until the interrupt cycle of that record has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Event request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_type | input | 10 | Event type code |
| req_payload | input | 448 | Seven 64-bit payload words, word 0 in the low bits |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| mem_wr_addr | output | 9 | Word address (slot*8 + word) |
| mem_wr_data | output | 64 | Word to write |
| cons_idx | input | 6 | Consumer index, as maintained by the consumer |
| prod_idx | output | 6 | Producer index (next slot to fill) |
| irq_pulse | output | 1 | One-cycle interrupt after a record is complete |
| irq_vec | output | 3 | Interrupt vector number (constant 5) |

## Verification
Two functions can coincide in one cycle: the full check on a pending request and a consumer index update that frees space. The bench provokes this by filling the ring until the producer index sits at 63 with the consumer at 0, so that the full comparison crosses the wrap point. It then holds a request high and moves cons_idx while that request waits. The behavioural model compares req_ready on every clock against its own full rule, so the request must be taken in exactly the cycle the slot frees and never before. The model also compares every memory write, interrupt and index value each cycle, with random write backpressure on the payload and header writes.

// File: rtl/evr_pkg.sv
package evr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_HEAD = 2'd2,
    ST_IRQ  = 2'd3
  } seq_state_t;

  // index of the slot after idx in a ring of depth slots
  function automatic int ring_step(input int idx, input int depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // word address of word sel inside slot idx
  function automatic int entry_addr(input int idx, input int sel, input int words_per_entry);
    return idx * words_per_entry + sel;
  endfunction

endpackage

// File: rtl/evr_ring_ptr.sv
module evr_ring_ptr
  import evr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] prod_idx,
  output logic             ring_full
);

  logic [IDX_W-1:0] prod_next;

  assign prod_next = IDX_W'(ring_step(int'(prod_idx), DEPTH));
  assign ring_full = (prod_next == cons_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_idx <= '0;
    else if (advance) prod_idx <= prod_next;
  end

  // R6
  prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_idx) |-> $past(advance));

endmodule

// File: rtl/evr_entry_fmt.sv
module evr_entry_fmt #(
  parameter int TYPE_W    = 10,
  parameter int DATA_W    = 64,
  parameter int PAY_WORDS = 7,
  parameter int RDY_BIT   = 31,
  parameter int TYPE_LSB  = 16,
  localparam int WPE      = PAY_WORDS + 1,
  localparam int SEL_W    = $clog2(WPE),
  localparam int HALF_W   = DATA_W / 2
) (
  input  logic [TYPE_W-1:0]           ev_type,
  input  logic [PAY_WORDS*DATA_W-1:0] payload,
  input  logic [SEL_W-1:0]            word_sel,
  output logic [DATA_W-1:0]           word_out
);

  logic [HALF_W-1:0] ctl_word;
  logic [DATA_W-1:0] words [WPE];

  always_comb begin
    ctl_word = '0;
    ctl_word[RDY_BIT] = 1'b1;
    ctl_word[TYPE_LSB +: TYPE_W] = ev_type;
  end

  // word 0 is the header: reserved half low, control half high
  assign words[0] = {ctl_word, {HALF_W{1'b0}}};

  for (genvar k = 1; k < WPE; k++) begin : g_body
    assign words[k] = payload[(k-1)*DATA_W +: DATA_W];
  end

  assign word_out = words[word_sel];

endmodule

// File: rtl/evr_wr_seq.sv
module evr_wr_seq
  import evr_pkg::*;
#(
  parameter int PAY_WORDS = 7,
  localparam int SEL_W    = $clog2(PAY_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             ring_full,
  input  logic             mem_ready,
  output logic             req_ready,
  output logic             load,
  output logic             mem_valid,
  output logic             hdr_phase,
  output logic             hdr_done,
  output logic             irq,
  output logic [SEL_W-1:0] word_sel
);

  seq_state_t st;
  logic       body_last;

  assign req_ready = (st == ST_IDLE) && !ring_full;
  assign load      = req_valid && req_ready;
  assign mem_valid = (st == ST_BODY) || (st == ST_HEAD);
  assign hdr_phase = (st == ST_HEAD);
  assign hdr_done  = hdr_phase && mem_ready;
  assign irq       = (st == ST_IRQ);
  assign body_last = (word_sel == SEL_W'(PAY_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      word_sel <= '0;
    end else begin
      case (st)
        ST_IDLE: if (load) begin
          st       <= ST_BODY;
          word_sel <= SEL_W'(1);
        end
        ST_BODY: if (mem_ready) begin
          if (body_last) begin
            st       <= ST_HEAD;
            word_sel <= '0;
          end else begin
            word_sel <= word_sel + 1'b1;
          end
        end
        ST_HEAD: if (mem_ready) st <= ST_IRQ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  irq_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> irq);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/evring_producer.sv
module evring_producer
  import evr_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int TYPE_W     = 10,
  parameter int DATA_W     = 64,
  parameter int PAY_WORDS  = 7,
  parameter int IRQ_VECTOR = 5,
  parameter int VEC_W      = 3,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int WPE       = PAY_WORDS + 1,
  localparam int SEL_W     = $clog2(WPE),
  localparam int ADDR_W    = $clog2(DEPTH * WPE),
  localparam int PAY_W     = PAY_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [PAY_W-1:0]  req_payload,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [IDX_W-1:0]  cons_idx,
  output logic [IDX_W-1:0]  prod_idx,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vec
);

  logic              ring_full;
  logic              load;
  logic              hdr_phase;
  logic              hdr_done;
  logic [SEL_W-1:0]  word_sel;
  logic [TYPE_W-1:0] type_q;
  logic [PAY_W-1:0]  pay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      pay_q  <= '0;
    end else if (load) begin
      type_q <= req_type;
      pay_q  <= req_payload;
    end
  end

  evr_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (hdr_done),
    .cons_idx  (cons_idx),
    .prod_idx  (prod_idx),
    .ring_full (ring_full)
  );

  evr_wr_seq #(.PAY_WORDS(PAY_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ring_full (ring_full),
    .mem_ready (mem_wr_ready),
    .req_ready (req_ready),
    .load      (load),
    .mem_valid (mem_wr_valid),
    .hdr_phase (hdr_phase),
    .hdr_done  (hdr_done),
    .irq       (irq_pulse),
    .word_sel  (word_sel)
  );

  evr_entry_fmt #(
    .TYPE_W    (TYPE_W),
    .DATA_W    (DATA_W),
    .PAY_WORDS (PAY_WORDS)
  ) u_fmt (
    .ev_type  (type_q),
    .payload  (pay_q),
    .word_sel (word_sel),
    .word_out (mem_wr_data)
  );

  assign mem_wr_addr = ADDR_W'(entry_addr(int'(prod_idx), int'(word_sel), WPE));
  assign irq_vec     = VEC_W'(IRQ_VECTOR);

  // R3
  hdr_ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && hdr_phase |-> mem_wr_data[DATA_W-1] && (mem_wr_data[DATA_W/2-1:0] == '0));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R7
  no_accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> !ring_full);

  // R8
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_wr_valid && !req_ready);

endmodule

// File: tb/evring_producer_tb.sv
`timescale 1ns/1ps
module evring_producer_tb;

  localparam int DEPTH = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [9:0]   req_type = '0;
  logic [447:0] req_payload = '0;
  logic         mem_wr_valid;
  logic         mem_wr_ready = 1'b1;
  logic [8:0]   mem_wr_addr;
  logic [63:0]  mem_wr_data;
  logic [5:0]   cons_idx = '0;
  logic [5:0]   prod_idx;
  logic         irq_pulse;
  logic [2:0]   irq_vec;

  int n_chk = 0;
  int n_err = 0;
  bit bp_en = 0;

  // behavioural reference state
  bit          m_busy = 0;
  bit          m_irq = 0;
  int          m_prod = 0;
  int          q_addr[$];
  logic [63:0] q_data[$];

  always #2 clk = ~clk;

  evring_producer u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_payload(req_payload),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .cons_idx(cons_idx), .prod_idx(prod_idx),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [447:0] mk_pay(input int seed);
    logic [447:0] p;
    for (int k = 0; k < 7; k++)
      p[k*64 +: 64] = {16'hC0DE, 16'(seed), 16'(k), 16'(seed * 7 + k * 3)};
    return p;
  endfunction

  // write backpressure
  always @(posedge clk) begin
    #1;
    mem_wr_ready = bp_en ? ($urandom_range(0, 1) == 1) : 1'b1;
  end

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit hdr_acc;
      bit exp_rdy;
      hdr_acc = 0;
      exp_rdy = !m_busy && (((m_prod + 1) % DEPTH) != int'(cons_idx));
      chk(req_ready == exp_rdy, m_busy ? "R8 ready while busy" : "R7 ready vs full",
          64'(req_ready), 64'(exp_rdy));
      chk(irq_pulse == m_irq, "R5 irq timing", 64'(irq_pulse), 64'(m_irq));
      chk(irq_vec == 3'd5, "R5 irq vector", 64'(irq_vec), 64'd5);
      chk(int'(prod_idx) == m_prod, "R6 producer index", 64'(prod_idx), 64'(m_prod));
      if (mem_wr_valid) begin
        if (q_addr.size() == 0) begin
          chk(0, "R2 unexpected write", 64'(mem_wr_addr), 64'd0);
        end else begin
          chk(int'(mem_wr_addr) == q_addr[0], q_addr.size() == 1 ? "R3 header addr" : "R2 payload addr",
              64'(mem_wr_addr), 64'(q_addr[0]));
          chk(mem_wr_data == q_data[0], q_addr.size() == 1 ? "R3 header data" : "R2 payload data",
              mem_wr_data, q_data[0]);
          if (mem_wr_ready) begin
            if (q_addr.size() == 1) hdr_acc = 1;
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
          end
        end
      end
      if (req_valid && req_ready) begin
        for (int k = 0; k < 7; k++) begin
          q_addr.push_back(m_prod * 8 + 1 + k);
          q_data.push_back(req_payload[k*64 +: 64]);
        end
        q_addr.push_back(m_prod * 8);
        q_data.push_back((64'd1 << 63) | (64'(req_type) << 48));
        m_busy = 1;
      end
      if (m_irq) m_busy = 0;
      m_irq = hdr_acc;
      if (hdr_acc) m_prod = (m_prod + 1) % DEPTH;
    end
  end

  task automatic post(input logic [9:0] t, input int seed);
    bit acc;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_type = t;
    req_payload = mk_pay(seed);
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int posted;
    posted = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(prod_idx == 6'd0, "R1 prod_idx", 64'(prod_idx), 64'd0);
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(mem_wr_valid == 1'b0, "R1 no write", 64'(mem_wr_valid), 64'd0);
    chk(irq_pulse == 1'b0, "R1 irq low", 64'(irq_pulse), 64'd0);

    // R2 R3 R5: plain records, no backpressure
    bp_en = 0;
    for (int i = 0; i < 4; i++) begin
      post(10'(i * 97 + 1), i);
      posted++;
    end
    wait_idle();
    chk(int'(prod_idx) == posted, "R6 count", 64'(prod_idx), 64'(posted));

    // R4: records under random write backpressure
    bp_en = 1;
    for (int i = 0; i < 6; i++) begin
      post(10'(1023 - i * 31), 100 + i);
      posted++;
    end
    wait_idle();
    chk(int'(prod_idx) == posted, "R6 count bp", 64'(prod_idx), 64'(posted));

    // fill to index 63 with consumer at 0
    bp_en = 0;
    while (posted < 63) begin
      post(10'(posted * 5), 200 + posted);
      posted++;
    end
    wait_idle();
    chk(prod_idx == 6'd63, "R6 index 63", 64'(prod_idx), 64'd63);

    // R7 full across the wrap point: request must wait
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_type = 10'h3FF;
    req_payload = mk_pay(999);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 held while full", 64'(req_ready), 64'd0);
      chk(mem_wr_valid == 1'b0, "R7 no write while full", 64'(mem_wr_valid), 64'd0);
    end
    @(posedge clk); #1;
    cons_idx = 6'd5;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when slot frees", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 busy after accept", 64'(req_ready), 64'd0);
    wait_idle();
    chk(prod_idx == 6'd0, "R6 wrap to 0", 64'(prod_idx), 64'd0);

    // records after wrap, with backpressure
    bp_en = 1;
    for (int i = 0; i < 3; i++) post(10'(i + 500), 300 + i);
    wait_idle();
    chk(prod_idx == 6'd3, "R6 after wrap", 64'(prod_idx), 64'd3);
    chk(q_addr.size() == 0, "R2 all writes seen", 64'(q_addr.size()), 64'd0);

    finish_run();
  end

endmodule